// File: doc/BRIEF.md
# Mode-Dependent Interrupt Pin Router

This block sits between the interrupt sources of a communication controller and the external interrupt pins of the device. It receives two controller interrupt lines, two timer event strobes and a raw low-voltage flag, and it places them on five pins `irq_pin[4:0]`. Each pin has a matching driver enable `irq_oe[4:0]`. The host interface mode, chosen by strap inputs, decides which source reaches which pin and which pins the router may drive at all.

The controller lines are qualified by a two-bit line-enable register and pass straight through as active-high pending levels. A pin drops low as soon as its source flag clears. Each timer strobe becomes a self-clearing high pulse of `PULSE_W` clock cycles. The low-voltage flag passes through a synchroniser before use. In non-multiplexed parallel mode the pins numbered 3 and 4 double as address inputs, so the router leaves them undriven. All five pins, their enables and the mode decode are fixed by the straps. No software access exists.

Top module: `irq_pin_router`

## Requirements
- R1: `irq_pin[0]` equals `ctl_line[0] & line_en[0]` in the same cycle in every valid mode, and is never high while `line_en[0]` is 0.
- R2: `irq_pin[1]` equals `ctl_line[1] & line_en[1]` in the same cycle in every valid mode.
- R3: Non-multiplexed mode is `strap_md = 3'b100` with `strap_mde[2] = 1`. In it, `irq_pin[2]` is the OR of timer pulse 0, timer pulse 1 and the synchronised low-voltage flag. `irq_oe = 5'b00111`, and `irq_pin[4:3]` are 0.
- R4: Multiplexed mode is `strap_md = 3'b100` with `strap_mde[2] = 0`. Serial mode is `strap_md = 3'b110`. In both, `irq_pin[2]` carries timer pulse 0, `irq_pin[3]` carries timer pulse 1 and `irq_pin[4]` carries the synchronised low-voltage flag. `irq_oe = 5'b11111`.
- R5: A timer strobe `tmr_evt[i]` that is high at a clock edge makes timer pulse i high for exactly `PULSE_W` cycles, starting just after that edge. The pulse then returns low by itself.
- R6: A strobe that arrives while a pulse is active restarts the count. The pulse then stays high for `PULSE_W` cycles after the edge of the latest strobe.
- R7: A change on `lowv_raw` reaches the routed pin after the second clock edge that follows it, through a two-flop synchroniser.
- R8: Every other strap code drives `irq_pin = 0` and `irq_oe = 0`.
- R9: While `rst_n` is low, the timer pulses and the synchronised low-voltage flag are cleared. Only the gated controller lines can then be high on the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_md | input | 3 | Interface mode straps |
| strap_mde | input | 3 | Mode expansion straps; bit 2 selects non-multiplexed |
| line_en | input | 2 | Controller interrupt line enables |
| ctl_line | input | 2 | Controller interrupt line levels |
| lowv_raw | input | 1 | Asynchronous low-voltage flag |
| tmr_evt | input | 2 | Timer event strobes, one cycle each |
| irq_pin | output | 5 | Interrupt pin levels, 1 = pending |
| irq_oe | output | 5 | Pin driver enables |

## Verification
A stuck or miscounted timer counter shows on pin 2 or pin 3. The pulse is then too short or too long, and the bench catches this within `PULSE_W + 1` cycles of the strobe, because every cycle is compared against a model of the pulse length. A missing or extra synchroniser stage shifts the low-voltage edge by one cycle, and the next cycle's comparison catches it. A wrong mode decode shows at once on `irq_oe`, because the bench checks the enable vector in every cycle and in every mode, the reserved codes included.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
   localparam int N_PINS = 5;
   localparam int N_TMR  = 2;
   localparam int N_LINE = 2;

   typedef enum logic [1:0] {
      RM_OFF    = 2'd0,
      RM_NONMUX = 2'd1,
      RM_MUX    = 2'd2,
      RM_SERIAL = 2'd3
   } route_mode_e;

   function automatic route_mode_e decode_straps(input logic [2:0] md, input logic [2:0] mde);
      route_mode_e m;
      m = RM_OFF;
      if (md == 3'b100) m = mde[2] ? RM_NONMUX : RM_MUX;
      else if (md == 3'b110) m = RM_SERIAL;
      return m;
   endfunction
endpackage

// File: rtl/irq_mode_decode.sv
module irq_mode_decode
   import irq_route_pkg::*;
(
   input  logic [2:0]  md_i,
   input  logic [2:0]  mde_i,
   output route_mode_e mode_o
);
   always_comb mode_o = decode_straps(md_i, mde_i);
endmodule

// File: rtl/irq_pulse_stretch.sv
module irq_pulse_stretch #(
   parameter int PULSE_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   output logic pulse_o
);
   localparam int CW = $clog2(PULSE_W + 1);

   initial begin
      if (PULSE_W < 1) $error("PULSE_W must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (evt_i)        cnt_q <= CW'(PULSE_W);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign pulse_o = (cnt_q != '0);

   assert_evt_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> pulse_o);
   assert_pulse_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CW'(1) && !evt_i) |=> !pulse_o);
   assert_retrigger_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_o && evt_i) |=> pulse_o);
endmodule

// File: rtl/irq_level_sync.sv
module irq_level_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   initial begin
      if (STAGES < 2) $error("STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-2:0], d_i};
   end

   assign q_o = sh_q[STAGES-1];

   assert_sync_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sh_q[STAGES-2] |=> q_o);
endmodule

// File: rtl/irq_pin_router.sv
module irq_pin_router
   import irq_route_pkg::*;
#(
   parameter int PULSE_W   = 8,
   parameter int LV_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       strap_md,
   input  logic [2:0]       strap_mde,
   input  logic [1:0]       line_en,
   input  logic [1:0]       ctl_line,
   input  logic             lowv_raw,
   input  logic [1:0]       tmr_evt,
   output logic [4:0]       irq_pin,
   output logic [4:0]       irq_oe
);
   localparam logic [N_PINS-1:0] OE_NONMUX = 5'b00111;
   localparam logic [N_PINS-1:0] OE_FULL   = '1;

   route_mode_e       mode;
   logic [N_TMR-1:0]  tpulse;
   logic              lv_sync;
   logic [N_LINE-1:0] lines;

   irq_mode_decode u_dec (
      .md_i   (strap_md),
      .mde_i  (strap_mde),
      .mode_o (mode)
   );

   for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
      irq_pulse_stretch #(.PULSE_W(PULSE_W)) u_str (
         .clk     (clk),
         .rst_n   (rst_n),
         .evt_i   (tmr_evt[t]),
         .pulse_o (tpulse[t])
      );
   end

   irq_level_sync #(.STAGES(LV_STAGES)) u_lv (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (lowv_raw),
      .q_o   (lv_sync)
   );

   assign lines = ctl_line & line_en;

   always_comb begin
      irq_pin = '0;
      irq_oe  = '0;
      unique case (mode)
         RM_NONMUX: begin
            irq_pin[N_LINE-1:0] = lines;
            irq_pin[2]          = (|tpulse) | lv_sync;
            irq_oe              = OE_NONMUX;
         end
         RM_MUX, RM_SERIAL: begin
            irq_pin = {lv_sync, tpulse, lines};
            irq_oe  = OE_FULL;
         end
         default: begin
            irq_pin = '0;
            irq_oe  = '0;
         end
      endcase
   end

   assert_line0_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !line_en[0] |-> !irq_pin[0]);
   assert_line1_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !line_en[1] |-> !irq_pin[1]);
   assert_nonmux_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (strap_md == 3'b100 && strap_mde[2]) |-> (irq_oe[4:3] == 2'b00 && irq_pin[4:3] == 2'b00));
   assert_undriven_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pin & ~irq_oe) == '0);
   assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (strap_md != 3'b100 && strap_md != 3'b110) |-> (irq_pin == '0 && irq_oe == '0));
endmodule

// File: tb/irq_pin_router_tb.sv
module irq_pin_router_tb_top;
   localparam int PW = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] strap_md = 3'b100;
   logic [2:0] strap_mde = 3'b000;
   logic [1:0] line_en = '0;
   logic [1:0] ctl_line = '0;
   logic       lowv_raw = 1'b0;
   logic [1:0] tmr_evt = '0;
   logic [4:0] irq_pin;
   logic [4:0] irq_oe;

   int checks = 0;
   int failures = 0;
   int m_cnt0 = 0, m_cnt1 = 0;
   logic m_lv1 = 0, m_lv2 = 0;
   bit done = 0;

   always #5 clk = ~clk;

   irq_pin_router #(.PULSE_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .strap_md(strap_md), .strap_mde(strap_mde),
      .line_en(line_en), .ctl_line(ctl_line), .lowv_raw(lowv_raw),
      .tmr_evt(tmr_evt), .irq_pin(irq_pin), .irq_oe(irq_oe)
   );

   // 0 = off, 1 = non-mux, 2 = mux/serial
   function automatic int mode_of(input logic [2:0] md, input logic [2:0] mde);
      if (md == 3'b100) return mde[2] ? 1 : 2;
      if (md == 3'b110) return 2;
      return 0;
   endfunction

   function automatic logic [9:0] expect_out(input int m, input logic [1:0] ln,
                                             input logic t0, input logic t1, input logic lv);
      logic [4:0] p, o;
      p = '0; o = '0;
      if (m == 1) begin p = {2'b00, t0 | t1 | lv, ln}; o = 5'b00111; end
      else if (m == 2) begin p = {lv, t1, t0, ln}; o = 5'b11111; end
      return {o, p};
   endfunction

   task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      if (!rst_n) begin
         m_cnt0 = 0; m_cnt1 = 0; m_lv1 = 0; m_lv2 = 0;
      end else begin
         m_cnt0 = tmr_evt[0] ? PW : (m_cnt0 > 0 ? m_cnt0 - 1 : 0);
         m_cnt1 = tmr_evt[1] ? PW : (m_cnt1 > 0 ? m_cnt1 - 1 : 0);
         m_lv2 = m_lv1; m_lv1 = lowv_raw;
      end
   endtask

   task automatic full_check(input string tag);
      logic [9:0] e;
      int m;
      m = mode_of(strap_md, strap_mde);
      e = expect_out(m, ctl_line & line_en, m_cnt0 > 0, m_cnt1 > 0, m_lv2);
      check(tag, {irq_oe, irq_pin}, e);
   endtask

   function automatic string mode_tag();
      case (mode_of(strap_md, strap_mde))
         1: return "R3 non-mux routing";
         2: return "R4 mux/serial routing";
         default: return "R8 reserved code quiet";
      endcase
   endfunction

   // advance one clock: model follows the edge, new inputs at negedge, check after
   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      tmr_evt = '0;
   endtask

   initial begin
      #1500000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int hi;
      void'($urandom(32'h1234_5678));
      // R9: reset state
      line_en = 2'b11; ctl_line = 2'b01; lowv_raw = 1'b1; tmr_evt = 2'b11;
      repeat (3) step();
      tmr_evt = 2'b11;
      #1;
      check("R9 reset state", {irq_oe, irq_pin}, {5'b11111, 5'b00001});
      tmr_evt = '0; lowv_raw = 1'b0;
      step(); rst_n = 1'b1;
      step(); step();

      // R1/R2: gating, mux mode
      strap_md = 3'b100; strap_mde = 3'b000;
      line_en = 2'b10; ctl_line = 2'b11; #1;
      full_check("R1 line0 gated off"); check("R2 line1 passes", {9'b0, irq_pin[1]}, 10'd1);
      line_en = 2'b01; #1;
      full_check("R1 line0 passes"); check("R2 line1 gated off", {9'b0, irq_pin[1]}, 10'd0);
      line_en = 2'b00; ctl_line = 2'b00;

      // R5: single pulse length on pin 2 (mux mode)
      tmr_evt = 2'b01;
      hi = 0;
      for (int i = 0; i < PW + 4; i++) begin
         step(); #1;
         if (irq_pin[2]) hi++;
         full_check("R5 timer pulse shape");
      end
      check("R5 pulse length", 10'(hi), 10'(PW));

      // R6: retrigger on timer 1, pin 3
      tmr_evt = 2'b10;
      step(); step(); step();
      tmr_evt = 2'b10;
      hi = 0;
      for (int i = 0; i < PW + 4; i++) begin
         step(); #1;
         if (irq_pin[3]) hi++;
         full_check("R6 retrigger shape");
      end
      check("R6 pulse after retrigger", 10'(hi), 10'(PW));

      // R7: low-voltage latency, serial mode pin 4
      strap_md = 3'b110; strap_mde = 3'b000;
      lowv_raw = 1'b1;
      step(); #1; check("R7 lv after one edge", {9'b0, irq_pin[4]}, 10'd0);
      step(); #1; check("R7 lv after two edges", {9'b0, irq_pin[4]}, 10'd1);
      lowv_raw = 1'b0;
      step(); #1; check("R7 lv fall one edge", {9'b0, irq_pin[4]}, 10'd1);
      step(); #1; check("R7 lv fall two edges", {9'b0, irq_pin[4]}, 10'd0);

      // R3: non-mux OR and undriven pins
      strap_md = 3'b100; strap_mde = 3'b100; lowv_raw = 1'b1;
      step(); step(); #1;
      check("R3 non-mux lv on pin2", {irq_oe, irq_pin}, {5'b00111, 5'b00100});
      lowv_raw = 1'b0; tmr_evt = 2'b10;
      step(); step(); #1;
      full_check("R3 non-mux timer1 on pin2");

      // R8: reserved code
      strap_md = 3'b111; line_en = 2'b11; ctl_line = 2'b11; #1;
      check("R8 reserved quiet", {irq_oe, irq_pin}, 10'd0);

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         if (n % 60 == 0) begin
            case ($urandom_range(0, 3))
               0: begin strap_md = 3'b100; strap_mde = 3'($urandom); end
               1: strap_md = 3'b110;
               2: begin strap_md = 3'b100; strap_mde = 3'b100; end
               default: strap_md = 3'($urandom);
            endcase
         end
         line_en  = 2'($urandom);
         ctl_line = 2'($urandom);
         tmr_evt  = {($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0)};
         if ($urandom_range(0, 19) == 0) lowv_raw = ~lowv_raw;
         #1;
         full_check(mode_tag());
         check("R1 R2 line gating", {8'b0, irq_pin[1:0]},
               {8'b0, (mode_of(strap_md, strap_mde) != 0) ? (ctl_line & line_en) : 2'b00});
         @(posedge clk);
         model_edge();
         @(negedge clk);
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule